// File: doc/BRIEF.md
# Refresh scheduler with partial-coverage self-refresh

This block paces the refresh of a four-bank DRAM. A cycle timer spreads the rows that must be refreshed evenly over the retention period. During normal operation every expiry of the timer adds one refresh to a debt counter. While that debt is non-zero, a request is shown to the command arbiter. The arbiter pays the debt back one refresh at a time through a request/acknowledge handshake. Several refreshes may be postponed, up to a parameter limit. When the limit is reached, an urgent flag tells the arbiter that it may no longer defer.

In self-refresh mode the arbiter is out of the loop. Each timer expiry fires a one-cycle strobe together with a bank mask and a row address. A 2-bit coverage code shrinks the mask to half or a quarter of the array to save power. A temperature-range input doubles the self-refresh interval when the part is cool. One row counter is shared by both modes and walks through all rows. A change of mode restarts the timer.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `req`, `urgent` and `sr_strobe` are low and `ref_row` is 0.
- R2: In normal mode (`self_ref`=0) the timer expires once every TICK cycles. Each expiry adds one pending refresh, and `req` is high exactly while the pending count is non-zero.
- R3: An `ack` sampled while `req` is high removes one pending refresh and advances `ref_row` by one, wrapping from 2^ROW_W-1 to 0. An `ack` while `req` is low has no effect.
- R4: The pending count never exceeds MAX_DEBT. `urgent` is high exactly while the count equals MAX_DEBT, and an expiry at that count is dropped.
- R5: In normal mode `ref_mask` is 4'b1111, because auto-refresh covers every bank.
- R6: In self-refresh mode `req` is low and the pending count is held. Each timer expiry drives `sr_strobe` high for one cycle, and `ref_row` advances by one after it.
- R7: In self-refresh mode `ref_mask` (bit n = bank n) follows `cov_code`: 2'b00 and 2'b11 give 4'b1111 (full array), 2'b01 gives 4'b0011 (banks 0 and 1), and 2'b10 gives 4'b0001 (bank 0 only).
- R8: In self-refresh mode with `cool`=1, the interval is 2*TICK cycles. `cool` has no effect in normal mode.
- R9: In a cycle where `self_ref` differs from its value in the previous cycle, no expiry occurs. The timer then counts from zero in the new mode. After reset the previous value is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_ref | input | 1 | Self-refresh mode enable |
| cov_code | input | 2 | Self-refresh coverage selection |
| cool | input | 1 | Low-temperature range flag |
| ack | input | 1 | Arbiter accepts the pending refresh |
| req | output | 1 | Refresh request to the arbiter |
| urgent | output | 1 | Postponement limit reached |
| sr_strobe | output | 1 | Self-refresh row refresh pulse |
| ref_mask | output | 4 | Banks covered by the current refresh |
| ref_row | output | ROW_W | Row address of the current refresh |

## Verification
The bench builds the block with TICK=5, ROW_W=3 and MAX_DEBT=3. With these values a timer expiry comes every few cycles, and the row counter wraps after eight refreshes. Holding off acknowledges for a short stretch is then enough to saturate the pending count. The same short run therefore covers debt saturation, row wrap, both self-refresh intervals and repeated mode switches alongside random handshakes.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int TICK     = 1950,
  parameter int ROW_W    = 12,
  parameter int MAX_DEBT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             self_ref,
  input  logic [1:0]       cov_code,
  input  logic             cool,
  input  logic             ack,
  output logic             req,
  output logic             urgent,
  output logic             sr_strobe,
  output logic [3:0]       ref_mask,
  output logic [ROW_W-1:0] ref_row
);
  localparam int CNT_W  = $clog2(2 * TICK);
  localparam int DEBT_W = $clog2(MAX_DEBT + 1);
  localparam logic [CNT_W-1:0]  LAST_N = CNT_W'(TICK - 1);
  localparam logic [CNT_W-1:0]  LAST_C = CNT_W'(2 * TICK - 1);
  localparam logic [DEBT_W-1:0] DMAX   = DEBT_W'(MAX_DEBT);

  logic [CNT_W-1:0]  cnt;
  logic [DEBT_W-1:0] debt;
  logic              sr_q;
  logic              stable, tick, take, inc;
  logic [CNT_W-1:0]  last;

  assign stable    = (self_ref == sr_q);
  assign last      = (self_ref && cool) ? LAST_C : LAST_N;
  assign tick      = stable && (cnt >= last);
  assign req       = (debt != '0) && !self_ref;
  assign urgent    = (debt == DMAX);
  assign take      = req && ack;
  assign inc       = tick && !self_ref;
  assign sr_strobe = tick && self_ref;

  always_comb begin
    ref_mask = 4'b1111;
    if (self_ref) begin
      case (cov_code)
        2'b01:   ref_mask = 4'b0011;
        2'b10:   ref_mask = 4'b0001;
        default: ref_mask = 4'b1111;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      debt    <= '0;
      sr_q    <= 1'b0;
      ref_row <= '0;
    end else begin
      sr_q <= self_ref;
      cnt  <= (!stable || tick) ? '0 : cnt + 1'b1;
      if (inc && !take && debt != DMAX) debt <= debt + 1'b1;
      else if (take && !inc)            debt <= debt - 1'b1;
      if (take || sr_strobe) ref_row <= ref_row + 1'b1;
    end
  end

  a_r4_debt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DMAX);

  a_r3_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ref_row == $past(ref_row) + 1'b1);

  a_r6_strobe_row: assert property (@(posedge clk) disable iff (!rst_n)
    sr_strobe |=> ref_row == $past(ref_row) + 1'b1);

  a_r6_debt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref && sr_q) |=> $stable(debt));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref != sr_q) |=> cnt == '0);

  a_r4_urgent_held: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && !take) |=> urgent);

  a_r7_bank0_covered: assert property (@(posedge clk) disable iff (!rst_n)
    sr_strobe |-> ref_mask[0]);

  a_r3_idle_row: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !sr_strobe) |=> $stable(ref_row));
endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int TICK = 5, ROW_W = 3, MAXD = 3;

  logic clk = 0, rst_n = 0, self_ref = 0, cool = 0, ack = 0;
  logic [1:0] cov_code = 0;
  logic req, urgent, sr_strobe;
  logic [3:0] ref_mask;
  logic [ROW_W-1:0] ref_row;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_cnt, m_debt, m_row, m_sr;

  always #4 clk = ~clk;

  refresh_sched #(.TICK(TICK), .ROW_W(ROW_W), .MAX_DEBT(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .self_ref(self_ref), .cov_code(cov_code),
    .cool(cool), .ack(ack), .req(req), .urgent(urgent),
    .sr_strobe(sr_strobe), .ref_mask(ref_mask), .ref_row(ref_row));

  function automatic int exp_mask(int sr, int code);
    if (!sr) return 15;
    if (code == 1) return 3;
    if (code == 2) return 1;
    return 15;
  endfunction

  function automatic int exp_last(int sr, int cl);
    return (sr && cl) ? 2 * TICK - 1 : TICK - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int sr, input int code, input int cl, input int ak);
    int stable, tick, e_req, take, inc;
    self_ref = sr[0]; cov_code = code[1:0]; cool = cl[0]; ack = ak[0];
    #1;
    stable = (sr == m_sr);
    tick   = stable && (m_cnt >= exp_last(sr, cl));
    e_req  = (m_debt > 0) && !sr;
    chk("R2 req", int'(req), e_req);
    chk("R4 urgent", int'(urgent), int'(m_debt == MAXD));
    chk("R6/R8/R9 sr_strobe", int'(sr_strobe), int'(tick && sr));
    chk(sr ? "R7 ref_mask" : "R5 ref_mask", int'(ref_mask), exp_mask(sr, code));
    chk("R3 ref_row", int'(ref_row), m_row);
    take = e_req && ak;
    inc  = tick && !sr;
    @(posedge clk);
    m_sr  = sr;
    m_cnt = (!stable || tick) ? 0 : m_cnt + 1;
    if (inc && !take && m_debt != MAXD) m_debt++;
    else if (take && !inc) m_debt--;
    if (take || (tick && sr)) m_row = (m_row + 1) % (1 << ROW_W);
    @(negedge clk);
  endtask

  initial begin
    int sr, code, cl;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 req", int'(req), 0);
    chk("R1 urgent", int'(urgent), 0);
    chk("R1 sr_strobe", int'(sr_strobe), 0);
    chk("R1 ref_row", int'(ref_row), 0);
    @(negedge clk);
    rst_n = 1;
    m_cnt = 0; m_debt = 0; m_row = 0; m_sr = 0;
    // R4: no acks, saturate
    for (int i = 0; i < 30; i++) step(0, 0, i % 2, 0);
    // R3: ack drain plus stray acks, row wrap
    for (int i = 0; i < 60; i++) step(0, 1, 1, 1);
    // R6/R7/R8: each coverage code, both temperatures
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 25; i++) step(1, c, t, i % 3 == 0);
    // R9: quick toggling
    for (int i = 0; i < 40; i++) step((i / 3) % 2, 2, 0, 1);
    // random mix
    sr = 0; code = 0; cl = 0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 39) == 0) sr = 1 - sr;
      if ($urandom_range(0, 9) == 0) code = $urandom_range(0, 3);
      if ($urandom_range(0, 19) == 0) cl = 1 - cl;
      step(sr, code, cl, $urandom_range(0, 3) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule